// File: doc/BRIEF.md
# Segmented Quadrature Angle Interpolator

This block turns a pair of signed, digitised quadrature samples (a sine-like and a cosine-like track) into an 8-bit angle within one signal period. The period is cut into eight 45-degree segments. Which segment the input lies in follows from the two signs and from which of the two magnitudes is larger. Inside a segment the ratio of the smaller magnitude to the larger one is tested against a per-segment table of thresholds, which gives the sub-step. The test uses multiplications only, so no divider is needed. Because each segment has its own step count and its own thresholds, a distorted or triangular input can still be mapped to an even, monotonic angle.

Each segment gets its own number of steps, so a period can hold from 8 up to 256 positions. The angle is the sum of the step counts of the segments that come before, plus the sub-step. A zero offset in whole segments moves where the count starts. An invert bit mirrors the direction of counting. A programmable hysteresis keeps the output from toggling between neighbouring sub-steps when the input sits on a threshold. The angle is registered. A one-cycle strobe marks every change of the angle, and a valid flag rises on the first cycle after reset.

Top module: `ang_interp`

## Requirements
- R1: The segment is chosen from the input signs and from `big` = (|sin| > |cos|). Sin ≥ 0, cos ≥ 0 gives segment 0 when !big and segment 1 when big. Sin ≥ 0, cos < 0 gives 2 when big and 3 otherwise. Sin < 0, cos < 0 gives 4 when !big and 5 otherwise. Sin < 0, cos ≥ 0 gives 6 when big and 7 otherwise.
- R2: Field p of `cfg_steps` is bits [5p+4:5p]. A field value v gives segment p v+1 steps (1 to 32). The period length is the sum of the eight step counts.
- R3: Let n be the step count of the segment. The count c is the number of thresholds T[i] with i < n-1 and min·256 > max·T[i], where min and max are the smaller and larger magnitude. In even segments the sub-step is c. In odd segments it is n-1-c.
- R4: A cycle with `thr_wr` high stores `thr_data` as threshold `thr_idx` (0 to 30) of segment `thr_seg`. It takes effect from the next cycle. Reset clears every threshold to 0.
- R5: The raw angle is the sub-step plus the step counts of all segments from segment `cfg_zero` up to the segment before the current one, counting upward modulo 8.
- R6: `cfg_zero` moves the zero position in whole segments. The segment numbered `cfg_zero` starts at raw angle 0.
- R7: With `cfg_invert` set, the output is (total - raw) modulo total, where total is the period length. Raw 0 therefore still gives 0.
- R8: Hysteresis applies while the segment is the same as in the previous cycle. Then thresholds with index below the previous count c are lowered by `cfg_hyst` (not below 0), and the others are raised by `cfg_hyst`. A change of segment compares without hysteresis.
- R9: `angle_stb_o` is high for exactly those cycles in which `angle_o` differs from its value in the cycle before.
- R10: In reset, `angle_o`, `angle_stb_o` and `angle_vld_o` are 0. `angle_o` shows the angle of the inputs present at the previous clock edge. `angle_vld_o` is 1 from the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sin_i | input | DW | Signed sine sample |
| cos_i | input | DW | Signed cosine sample |
| cfg_steps | input | 40 | Per-segment step count minus one, 5 bits per segment |
| cfg_zero | input | 3 | Zero offset in segments |
| cfg_invert | input | 1 | Mirror the counting direction |
| cfg_hyst | input | TW | Hysteresis on threshold comparisons |
| thr_wr | input | 1 | Threshold write enable |
| thr_seg | input | 3 | Segment of the threshold being written |
| thr_idx | input | 5 | Index of the threshold being written (0 to 30) |
| thr_data | input | TW | Threshold value, ratio scaled by 256 |
| angle_o | output | 8 | Registered angle |
| angle_stb_o | output | 1 | One-cycle strobe on a change of the angle |
| angle_vld_o | output | 1 | Angle valid since reset release |

## Verification
The conversion is first driven with single on-axis and diagonal points whose angles are worked out by hand. These show whether the segment coding, the mirrored sub-step in odd segments and the base sums are right. Slow noisy rotations in both directions, over uniform and random step tables, are compared every cycle against a behavioural model. This separates errors in the threshold count from errors in base accumulation at every segment boundary. Zero-offset, inverted and all-single-step setups isolate the rotation, mirror and length arithmetic. A small input that dithers around the first threshold, with and without hysteresis, separates the raise and lower rules from plain comparison.

// File: rtl/ang_pkg.sv
// Shared constants and types of the segmented angle interpolator.
// Assumes a fixed split of one period into eight segments.
package ang_pkg;
    localparam int unsigned NSEG    = 8;
    localparam int unsigned SEGW    = $clog2(NSEG);
    localparam int unsigned MAXSTEP = 32;
    localparam int unsigned STW     = $clog2(MAXSTEP);
    localparam int unsigned NTHR    = MAXSTEP - 1;
    localparam int unsigned IDXW    = STW;
    localparam int unsigned ANGW    = 8;
    typedef logic [SEGW-1:0] seg_t;
endpackage

// File: rtl/ang_octant.sv
// Segment finder: works out the 45-degree segment from the input signs and
// from which magnitude is larger. It also gives the smaller and larger
// magnitude. Assumes two's-complement inputs. The most negative code gives
// a magnitude of 2^(DW-1), which is held as unsigned.
module ang_octant import ang_pkg::*; #(
    parameter int unsigned DW = 12
) (
    input  logic signed [DW-1:0] sin_i,
    input  logic signed [DW-1:0] cos_i,
    output seg_t                 seg_o,
    output logic [DW-1:0]        mag_min_o,
    output logic [DW-1:0]        mag_max_o
);
    logic [DW-1:0] abs_s;
    logic [DW-1:0] abs_c;
    logic          big;
    logic [1:0]    quad;

    // Magnitudes of both tracks.
    always_comb begin
        abs_s = sin_i[DW-1] ? (~sin_i + {{(DW-1){1'b0}}, 1'b1}) : sin_i;
        abs_c = cos_i[DW-1] ? (~cos_i + {{(DW-1){1'b0}}, 1'b1}) : cos_i;
    end

    // Quadrant from the signs, then the half within it from the magnitude test.
    always_comb begin
        big       = abs_s > abs_c;
        quad      = {sin_i[DW-1], sin_i[DW-1] ^ cos_i[DW-1]};
        seg_o     = {quad, quad[0] ? ~big : big};
        mag_min_o = big ? abs_c : abs_s;
        mag_max_o = big ? abs_s : abs_c;
    end
endmodule

// File: rtl/ang_thr_bank.sv
// Threshold store: one table of NTHR ratio thresholds per segment, written
// one entry per cycle. The full table of the selected segment is read out
// without a clock. Index values above NTHR-1 are not stored.
module ang_thr_bank import ang_pkg::*; #(
    parameter int unsigned TW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  seg_t               wr_seg,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [TW-1:0]      wr_data,
    input  seg_t               rd_seg,
    output logic [NTHR*TW-1:0] rd_thr
);
    logic [TW-1:0] mem [NSEG][NTHR];

    // Clear on reset, otherwise take one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEG; s++) begin
                for (int i = 0; i < NTHR; i++) begin
                    mem[s][i] <= '0;
                end
            end
        end else if (wr_en && (wr_idx < IDXW'(NTHR))) begin
            mem[wr_seg][wr_idx] <= wr_data;
        end
    end

    generate
        for (genvar i = 0; i < NTHR; i++) begin : g_rd
            assign rd_thr[i*TW +: TW] = mem[rd_seg][i];
        end
    endgenerate
endmodule

// File: rtl/ang_substep.sv
// Sub-step finder: counts the thresholds that the magnitude ratio passes,
// using min*2^TW > max*T in place of a division. With hold_en set,
// thresholds below the previous count are lowered by hyst and the rest
// raised by hyst. In odd segments the count is mirrored, because the ratio
// falls as the angle rises. Assumes each table is ascending.
module ang_substep import ang_pkg::*; #(
    parameter int unsigned DW = 12,
    parameter int unsigned TW = 8
) (
    input  logic [DW-1:0]      mag_min,
    input  logic [DW-1:0]      mag_max,
    input  logic [NTHR*TW-1:0] thr_vec,
    input  logic [IDXW-1:0]    last_idx,
    input  logic               mirror,
    input  logic [TW-1:0]      hyst,
    input  logic               hold_en,
    input  logic [IDXW-1:0]    hold_cnt,
    output logic [IDXW-1:0]    cnt_o,
    output logic [IDXW-1:0]    sub_o
);
    localparam int unsigned PW = DW + TW + 1;

    logic [PW-1:0]   lhs;
    logic [NTHR-1:0] pass;

    assign lhs = {1'b0, mag_min, {TW{1'b0}}};

    generate
        for (genvar i = 0; i < NTHR; i++) begin : g_cmp
            logic [TW:0]   t_raw;
            logic [TW:0]   t_eff;
            logic [PW-1:0] rhs;
            assign t_raw = {1'b0, thr_vec[i*TW +: TW]};
            // Shift the threshold away from the side the output now sits on.
            always_comb begin
                if (!hold_en) begin
                    t_eff = t_raw;
                end else if (IDXW'(i) < hold_cnt) begin
                    t_eff = (t_raw > {1'b0, hyst}) ? (t_raw - {1'b0, hyst}) : '0;
                end else begin
                    t_eff = t_raw + {1'b0, hyst};
                end
            end
            assign rhs     = PW'(mag_max) * PW'(t_eff);
            assign pass[i] = (IDXW'(i) < last_idx) && (lhs > rhs);
        end
    endgenerate

    // Population count of passed thresholds.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NTHR; i++) begin
            cnt_o = cnt_o + IDXW'(pass[i]);
        end
    end

    assign sub_o = mirror ? (last_idx - cnt_o) : cnt_o;
endmodule

// File: rtl/ang_interp.sv
// Segmented quadrature angle interpolator, top level. Joins the segment
// finder, the threshold store and the sub-step finder. Adds the base of the
// segment in rotated order, applies the direction mirror and registers the
// angle with a change strobe. Assumes the configuration inputs are
// quasi-static.
module ang_interp import ang_pkg::*; #(
    parameter int unsigned DW = 12,
    parameter int unsigned TW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] sin_i,
    input  logic signed [DW-1:0] cos_i,
    input  logic [NSEG*STW-1:0]  cfg_steps,
    input  logic [SEGW-1:0]      cfg_zero,
    input  logic                 cfg_invert,
    input  logic [TW-1:0]        cfg_hyst,
    input  logic                 thr_wr,
    input  logic [SEGW-1:0]      thr_seg,
    input  logic [IDXW-1:0]      thr_idx,
    input  logic [TW-1:0]        thr_data,
    output logic [ANGW-1:0]      angle_o,
    output logic                 angle_stb_o,
    output logic                 angle_vld_o
);
    localparam int unsigned SUMW = ANGW + 1;

    seg_t              seg_w;
    seg_t              rot_w;
    logic [DW-1:0]     mn_w;
    logic [DW-1:0]     mx_w;
    logic [NTHR*TW-1:0] thr_w;
    logic [IDXW-1:0]   last_w;
    logic [IDXW-1:0]   cnt_w;
    logic [IDXW-1:0]   sub_w;
    logic [SUMW-1:0]   seg_len [NSEG];
    logic [SUMW-1:0]   total;
    logic [SUMW-1:0]   base;
    logic [SUMW-1:0]   raw;
    logic [SUMW-1:0]   ang_full;
    logic [ANGW-1:0]   ang_nxt;
    logic              hold_en;
    seg_t              hold_seg_q;
    logic [IDXW-1:0]   hold_cnt_q;

    ang_octant #(.DW(DW)) u_oct (
        .sin_i     (sin_i),
        .cos_i     (cos_i),
        .seg_o     (seg_w),
        .mag_min_o (mn_w),
        .mag_max_o (mx_w)
    );

    ang_thr_bank #(.TW(TW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (thr_wr),
        .wr_seg  (thr_seg),
        .wr_idx  (thr_idx),
        .wr_data (thr_data),
        .rd_seg  (seg_w),
        .rd_thr  (thr_w)
    );

    assign last_w  = cfg_steps[seg_w*STW +: STW];
    assign hold_en = angle_vld_o && (seg_w == hold_seg_q);

    ang_substep #(.DW(DW), .TW(TW)) u_sub (
        .mag_min  (mn_w),
        .mag_max  (mx_w),
        .thr_vec  (thr_w),
        .last_idx (last_w),
        .mirror   (seg_w[0]),
        .hyst     (cfg_hyst),
        .hold_en  (hold_en),
        .hold_cnt (hold_cnt_q),
        .cnt_o    (cnt_w),
        .sub_o    (sub_w)
    );

    generate
        for (genvar p = 0; p < NSEG; p++) begin : g_len
            assign seg_len[p] = SUMW'(cfg_steps[p*STW +: STW]) + SUMW'(1);
        end
    endgenerate

    // Period length as the sum of all segment lengths.
    always_comb begin
        total = '0;
        for (int p = 0; p < NSEG; p++) begin
            total = total + seg_len[p];
        end
    end

    // Base of the current segment, summed in order from the zero segment.
    always_comb begin
        rot_w = seg_w - cfg_zero;
        base  = '0;
        for (int j = 0; j < NSEG; j++) begin
            if (SEGW'(j) < rot_w) begin
                base = base + seg_len[SEGW'(cfg_zero + SEGW'(j))];
            end
        end
    end

    // Raw position and optional mirror about zero.
    always_comb begin
        raw      = base + SUMW'(sub_w);
        ang_full = cfg_invert ? ((raw == '0) ? '0 : (total - raw)) : raw;
        ang_nxt  = ang_full[ANGW-1:0];
    end

    // Output register, change strobe and hysteresis state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            angle_o     <= '0;
            angle_stb_o <= 1'b0;
            angle_vld_o <= 1'b0;
            hold_seg_q  <= '0;
            hold_cnt_q  <= '0;
        end else begin
            angle_o     <= ang_nxt;
            angle_stb_o <= (ang_nxt != angle_o);
            angle_vld_o <= 1'b1;
            hold_seg_q  <= seg_w;
            hold_cnt_q  <= cnt_w;
        end
    end

    // A change of the angle is always flagged (R9).
    p_stb_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (angle_o != $past(angle_o)) |-> angle_stb_o);

    // The strobe never fires without a change (R9).
    p_stb_only_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        angle_stb_o |-> (angle_o != $past(angle_o)));

    // Valid one cycle after reset is released (R10).
    p_vld_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> angle_vld_o);

    // The angle stays inside the configured period (R5).
    p_angle_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (angle_vld_o && $stable(cfg_steps)) |-> (SUMW'(angle_o) < total));

    // First-quadrant inputs land in segment 0 or 1 (R1).
    p_first_quadrant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sin_i[DW-1] && !cos_i[DW-1]) |-> (seg_w <= 3'd1));
endmodule

// File: tb/sim_ang_interp.sv
// Bench for ang_interp: a behavioural model compared every cycle, plus
// hand-worked directed points.
module sim_ang_interp;
    localparam int DW = 12;
    localparam int TW = 8;
    localparam real PI = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] sin_d = '0;
    logic signed [DW-1:0] cos_d = '0;
    logic [39:0]          cfg_steps = {8{5'd31}};
    logic [2:0]           cfg_zero = '0;
    logic                 cfg_inv = 1'b0;
    logic [TW-1:0]        cfg_hyst = '0;
    logic                 thr_wr = 1'b0;
    logic [2:0]           thr_seg = '0;
    logic [4:0]           thr_idx = '0;
    logic [TW-1:0]        thr_data = '0;
    logic [7:0]           angle_o;
    logic                 angle_stb_o;
    logic                 angle_vld_o;

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R10";
    bit    started = 0;
    bit    done = 0;
    int    thr_m [8][31];
    int    exp_ang, exp_stb, exp_vld;
    bit    m_vld;
    int    m_seg, m_cnt;

    always #4 clk = ~clk;

    ang_interp #(.DW(DW), .TW(TW)) u0 (
        .clk (clk), .rst_n (rst_n), .sin_i (sin_d), .cos_i (cos_d),
        .cfg_steps (cfg_steps), .cfg_zero (cfg_zero), .cfg_invert (cfg_inv),
        .cfg_hyst (cfg_hyst), .thr_wr (thr_wr), .thr_seg (thr_seg),
        .thr_idx (thr_idx), .thr_data (thr_data), .angle_o (angle_o),
        .angle_stb_o (angle_stb_o), .angle_vld_o (angle_vld_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int steps_of(int p);
        return int'(cfg_steps[p*5 +: 5]) + 1;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int s, c, as, ac, mn, mx, q, sg, nst, cnt, sub, acc, p, raw, tot, res, t, h;
        bit big;
        started = 1;
        if (!rst_n) begin
            exp_ang = 0; exp_stb = 0; exp_vld = 0;
            m_vld = 0; m_seg = 0; m_cnt = 0;
            foreach (thr_m[a, b]) thr_m[a][b] = 0;
        end else begin
            s = int'(sin_d); c = int'(cos_d);
            as = (s < 0) ? -s : s;
            ac = (c < 0) ? -c : c;
            big = as > ac;
            if (s >= 0) q = (c >= 0) ? 0 : 1;
            else        q = (c < 0) ? 2 : 3;
            if (q % 2 == 1) sg = 2 * q + (big ? 0 : 1);
            else            sg = 2 * q + (big ? 1 : 0);
            mn = big ? ac : as;
            mx = big ? as : ac;
            nst = steps_of(sg);
            h = int'(cfg_hyst);
            cnt = 0;
            for (int i = 0; i < nst - 1; i++) begin
                t = thr_m[sg][i];
                if (m_vld && sg == m_seg) t = (i < m_cnt) ? ((t > h) ? t - h : 0) : t + h;
                if (longint'(mn) * 256 > longint'(mx) * t) cnt++;
            end
            sub = (sg % 2 == 1) ? nst - 1 - cnt : cnt;
            acc = 0;
            p = int'(cfg_zero);
            while (p != sg) begin
                acc += steps_of(p);
                p = (p + 1) % 8;
            end
            raw = acc + sub;
            tot = 0;
            for (int k = 0; k < 8; k++) tot += steps_of(k);
            res = cfg_inv ? (tot - raw) % tot : raw;
            exp_stb = (res != exp_ang) ? 1 : 0;
            exp_ang = res; exp_vld = 1;
            m_vld = 1; m_seg = sg; m_cnt = cnt;
            if (thr_wr && thr_idx < 31) thr_m[thr_seg][thr_idx] = int'(thr_data);
        end
    end

    // Cycle comparison against the model (R9 strobe, R10 valid).
    always @(negedge clk) begin
        if (started && !done) begin
            check(phase, "angle vs model", int'(angle_o), exp_ang);
            check("R9", "strobe vs model", int'(angle_stb_o), exp_stb);
            check("R10", "valid vs model", int'(angle_vld_o), exp_vld);
        end
    end

    task automatic put(int s, int c);
        sin_d = DW'(s);
        cos_d = DW'(c);
        @(negedge clk);
    endtask

    task automatic sweep(int n, real turns, int amp);
        for (int k = 0; k < n; k++) begin
            real a;
            a = 2.0 * PI * turns * k / n;
            put($rtoi(amp * $sin(a)) + int'($urandom_range(6)) - 3,
                $rtoi(amp * $cos(a)) + int'($urandom_range(6)) - 3);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual %0d cycles expected completion", 200000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "angle in reset", int'(angle_o), 0);
        check("R10", "strobe in reset", int'(angle_stb_o), 0);
        check("R10", "valid in reset", int'(angle_vld_o), 0);
        sin_d = DW'(10);
        cos_d = DW'(1000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "valid one cycle after release", int'(angle_vld_o), 1);
        check("R4", "cleared thresholds all passed", int'(angle_o), 31);

        phase = "R4";
        for (int sg = 0; sg < 8; sg++) begin
            for (int i = 0; i < 31; i++) begin
                thr_wr = 1'b1;
                thr_seg = 3'(sg);
                thr_idx = 5'(i);
                thr_data = TW'($rtoi($tan((i + 1) * (PI / 4.0) / 32.0) * 256.0 + 0.5));
                @(negedge clk);
            end
        end
        thr_wr = 1'b0;
        put(10, 1000);
        check("R4", "programmed thresholds", int'(angle_o), 0);

        phase = "R1";
        put(0, 1000);     check("R1", "segment 0 axis", int'(angle_o), 0);
        put(0, 1000);     check("R9", "no strobe when steady", int'(angle_stb_o), 0);
        put(1000, 0);     check("R1", "segment 1 end", int'(angle_o), 63);
        check("R9", "strobe on change", int'(angle_stb_o), 1);
        put(1000, 0);     check("R9", "strobe lasts one cycle", int'(angle_stb_o), 0);
        put(0, -1000);    check("R1", "segment 3 end", int'(angle_o), 127);
        put(-1000, 0);    check("R5", "segment 6 base", int'(angle_o), 192);
        put(700, 700);    check("R3", "diagonal passes all", int'(angle_o), 31);

        phase = "R3";
        sweep(1024, 4.0, 1800);
        sweep(512, -2.0, 1500);

        phase = "R2";
        cfg_steps = {8'($urandom), 32'($urandom)};
        sweep(512, 2.0, 1700);
        cfg_steps = '0;
        put(1000, 0);     check("R2", "single step segment 1", int'(angle_o), 1);
        put(-1000, 0);    check("R2", "single step segment 6", int'(angle_o), 6);
        sweep(128, 1.0, 1600);

        phase = "R6";
        cfg_steps = {8{5'd31}};
        cfg_zero = 3'd2;
        put(0, 1000);     check("R6", "zero at segment 2", int'(angle_o), 192);
        put(1000, 0);     check("R6", "last segment of rotated period", int'(angle_o), 255);
        sweep(512, 2.0, 1800);

        phase = "R7";
        cfg_zero = 3'd0;
        cfg_inv = 1'b1;
        put(1000, 0);     check("R7", "mirrored 63", int'(angle_o), 193);
        put(0, 1000);     check("R7", "mirrored zero", int'(angle_o), 0);
        put(700, 700);    check("R7", "mirrored 31", int'(angle_o), 225);
        sweep(512, -2.0, 1800);
        cfg_inv = 1'b0;

        phase = "R8";
        put(0, 1000);
        cfg_hyst = TW'(20);
        put(10, 1000);    check("R8", "below threshold", int'(angle_o), 0);
        put(50, 1000);    check("R8", "raised threshold holds", int'(angle_o), 0);
        put(120, 1000);   check("R8", "crossing raised threshold", int'(angle_o), 1);
        put(50, 1000);    check("R8", "lowered threshold holds", int'(angle_o), 1);
        put(0, 1000);     check("R8", "falls back at zero", int'(angle_o), 0);
        cfg_hyst = '0;
        put(50, 1000);    check("R8", "no hysteresis switches", int'(angle_o), 1);
        cfg_hyst = TW'(12);
        sweep(1024, 2.0, 1800);
        sweep(512, -1.0, 1200);
        cfg_hyst = '0;

        @(negedge clk);
        finish_run();
    end
endmodule